// File: doc/BRIEF.md
# Gated-Clock Johnson Decade Counter

This block counts in tens with a five-stage twisted-ring register. Its ten active-high decoded outputs show the current state as a one-hot word. An active-low carry shows whether the count sits in the upper half of the decade.

Two asynchronous count lines reach the block and are oversampled by the system clock. One line counts on a rising edge and the other on a falling edge. Each line only counts while the other one sits at its enabling level. The carry output can drive the rising-edge count line of a following stage.

A master reset clears the block at once. It takes effect without waiting for a clock edge and is released in step with the clock. The ring corrects itself from any illegal code within eleven counts. A test load port writes an arbitrary five-bit code into the ring, so that recovery can be exercised.

Top module: `johnson_decade_ctr`

## Requirements
- R1: While `mreset` is high the block is in state 0 (`dec_q` = 10'b0000000001, `carry_n` = 1), and this takes effect immediately, without a clock edge.
- R2: The legal ring codes, written as `test_code` with bit i holding stage i, are: state k for k in 0..5 has bits 0..k-1 set; state k for k in 6..9 has bits k-5..4 set. In state k only `dec_q[k]` is high, and each count moves the high bit from k to k+1.
- R3: A rising edge on `trig_rise` while `trig_fall_n` is low advances the count by one. The new state shows on the outputs on the third rising clock edge after the input change.
- R4: A falling edge on `trig_fall_n` while `trig_rise` is high advances the count by one, with the same latency as R3.
- R5: No other activity on the count lines changes the state. This covers a falling edge on `trig_rise`, a rising edge on `trig_rise` while `trig_fall_n` is high, a rising edge on `trig_fall_n`, and a falling edge on `trig_fall_n` while `trig_rise` is low.
- R6: `carry_n` is low in states 5 to 9 and high in states 0 to 4.
- R7: From any of the 22 illegal ring codes, at most 11 counts bring the ring back into the legal sequence. After that it steps through the legal states in order.
- R8: `test_ld` high at a rising clock edge writes `test_code` into the ring, which shows on the outputs after that edge. An illegal code never decodes as a one-hot word.
- R9: The count wraps from state 9 to state 0.
- R10: A count edge that reaches the count lines while `mreset` is high, or at the moment `mreset` is released, is discarded. Edges that arrive later count normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mreset | input | 1 | Master reset, active high, asynchronous assertion |
| trig_rise | input | 1 | Count line, rising-edge active, enables the other line when high |
| trig_fall_n | input | 1 | Count line, falling-edge active, enables the other line when low |
| test_ld | input | 1 | Test load strobe |
| test_code | input | 5 | Ring code written by the test load, bit i = stage i |
| dec_q | output | 10 | One-hot decoded state |
| carry_n | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
A change on a count line passes two synchronizer flops and one history flop. The resulting count therefore appears at the third rising edge after the change. The bench drives every input on a falling clock edge and waits four full cycles before it samples, so each result has settled by the time it is read.

A test load appears one edge after the strobe and is sampled on the next falling edge. The effect of reset is checked one nanosecond after `mreset` rises, before any clock edge follows. The recovery sweep loads each illegal code and counts until the output is one-hot, with a limit of eleven counts. It then follows the next ten states.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  localparam int unsigned RING_W    = 5;
  localparam int unsigned N_STATES  = 2 * RING_W;
  localparam int unsigned N_LINES   = 2;
  localparam int unsigned LINE_RISE = 0;
  localparam int unsigned LINE_FALL = 1;

  typedef logic [RING_W-1:0]   ring_t;
  typedef logic [N_STATES-1:0] onehot_t;

  // Twisted-ring step. The second stage carries a guard term: it loads a
  // one only when stage 1 is already set or the last stage is clear.
  // Legal codes never see the difference, and illegal ones are squeezed
  // back into the ten-state loop.
  function automatic ring_t ring_next(input ring_t r);
    ring_t n;
    n[0] = ~r[RING_W-1];
    n[1] = r[0] & (r[1] | ~r[RING_W-1]);
    for (int i = 2; i < RING_W; i++) begin
      n[i] = r[i-1];
    end
    return n;
  endfunction
endpackage

// File: rtl/jdc_sync_edge.sv
module jdc_sync_edge #(
  parameter int unsigned LINES       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prv
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    logic                   hist;

    always_ff @(posedge clk) begin
      chain <= {chain[TOP-1:0], raw[g]};
      hist  <= chain[TOP];
    end

    assign cur[g] = chain[TOP];
    assign prv[g] = hist;
  end
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
  import jdc_pkg::*;
#(
  parameter int unsigned RELEASE_LEN = 3
) (
  input  logic  clk,
  input  logic  mreset,
  input  logic  adv,
  input  logic  ld_en,
  input  ring_t ld_val,
  output ring_t ring
);
  logic [RELEASE_LEN-1:0] rel;
  logic                   hold;

  // The hold is set at once by reset and falls RELEASE_LEN edges later.
  always_ff @(posedge clk or posedge mreset) begin
    if (mreset) rel <= '1;
    else        rel <= {rel[RELEASE_LEN-2:0], 1'b0};
  end

  assign hold = rel[RELEASE_LEN-1];

  always_ff @(posedge clk or posedge mreset) begin
    if (mreset)     ring <= '0;
    else if (hold)  ring <= '0;
    else if (ld_en) ring <= ld_val;
    else if (adv)   ring <= ring_next(ring);
  end
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode
  import jdc_pkg::*;
(
  input  ring_t   ring,
  output onehot_t dec
);
  for (genvar k = 0; k < N_STATES; k++) begin : g_state
    if (k == 0) begin : g_zero
      assign dec[k] = ~ring[0] & ~ring[RING_W-1];
    end else if (k < RING_W) begin : g_fill
      assign dec[k] = ring[k-1] & ~ring[k];
    end else if (k == RING_W) begin : g_full
      assign dec[k] = ring[RING_W-1] & ring[0];
    end else begin : g_drain
      assign dec[k] = ~ring[k-RING_W-1] & ring[k-RING_W];
    end
  end
endmodule

// File: rtl/johnson_decade_ctr.sv
module johnson_decade_ctr
  import jdc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RELEASE_LEN = 3
) (
  input  logic              clk,
  input  logic              mreset,
  input  logic              trig_rise,
  input  logic              trig_fall_n,
  input  logic              test_ld,
  input  logic [RING_W-1:0] test_code,
  output logic [N_STATES-1:0] dec_q,
  output logic              carry_n
);
  logic [N_LINES-1:0] raw, cur, prv;
  logic               rise_ev, fall_ev, adv;
  ring_t              ring;

  assign raw[LINE_RISE] = trig_rise;
  assign raw[LINE_FALL] = trig_fall_n;

  jdc_sync_edge #(
    .LINES      (N_LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .raw(raw),
    .cur(cur),
    .prv(prv)
  );

  // Each line is gated by the current synchronized level of the other line.
  assign rise_ev = cur[LINE_RISE] & ~prv[LINE_RISE] & ~cur[LINE_FALL];
  assign fall_ev = ~cur[LINE_FALL] & prv[LINE_FALL] & cur[LINE_RISE];
  assign adv     = rise_ev | fall_ev;

  jdc_ring #(
    .RELEASE_LEN(RELEASE_LEN)
  ) u_ring (
    .clk   (clk),
    .mreset(mreset),
    .adv   (adv),
    .ld_en (test_ld),
    .ld_val(test_code),
    .ring  (ring)
  );

  jdc_decode u_dec (
    .ring(ring),
    .dec (dec_q)
  );

  assign carry_n = ~ring[RING_W-1];
endmodule

// File: rtl/jdc_checker.sv
module jdc_checker (
  input logic       clk,
  input logic       mreset,
  input logic       trig_rise,
  input logic       trig_fall_n,
  input logic       test_ld,
  input logic [9:0] dec_q,
  input logic       carry_n
);
  always @(negedge clk) begin
    if (mreset) begin
      AST_RST_STATE: assert (dec_q == 10'b0000000001 && carry_n == 1'b1); // R1
    end
  end

  AST_CARRY_HALF: assert property (@(posedge clk) disable iff (mreset)
    $onehot(dec_q) |-> (carry_n == ~|dec_q[9:5])); // R6

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (mreset)
    ($onehot(dec_q) && !test_ld) |=>
      ($stable(dec_q) || dec_q == {$past(dec_q[8:0]), $past(dec_q[9])})); // R2

  // The window matches the default two synchronizer stages plus one history flop.
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (mreset)
    (!test_ld && $past(trig_rise, 2) == $past(trig_rise, 3)
              && $past(trig_fall_n, 2) == $past(trig_fall_n, 3)) |=> $stable(dec_q)); // R5

  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (mreset)
    $past(mreset) |=> (dec_q == 10'b0000000001)); // R10
endmodule

bind johnson_decade_ctr jdc_checker u_chk (
  .clk        (clk),
  .mreset     (mreset),
  .trig_rise  (trig_rise),
  .trig_fall_n(trig_fall_n),
  .test_ld    (test_ld),
  .dec_q      (dec_q),
  .carry_n    (carry_n)
);

// File: tb/johnson_decade_ctr_tb.sv
`timescale 1ns/1ps
module johnson_decade_ctr_tb;
  logic       clk = 1'b0;
  logic       mreset, trig_rise, trig_fall_n, test_ld;
  logic [4:0] test_code;
  logic [9:0] dec_q;
  logic       carry_n;
  int         n_chk = 0;
  int         n_bad = 0;
  int         st;

  always #2.5 clk = ~clk;

  johnson_decade_ctr u_dut (
    .clk(clk), .mreset(mreset), .trig_rise(trig_rise), .trig_fall_n(trig_fall_n),
    .test_ld(test_ld), .test_code(test_code), .dec_q(dec_q), .carry_n(carry_n)
  );

  function automatic logic [4:0] jcode(input int k);
    if (k <= 5) return 5'((1 << k) - 1);
    return 5'(5'b11111 << (k - 5));
  endfunction

  function automatic bit is_legal(input logic [4:0] c);
    for (int k = 0; k < 10; k++) if (jcode(k) == c) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int hot_index(input logic [9:0] d);
    for (int k = 0; k < 10; k++) if (d[k]) return k;
    return -1;
  endfunction

  task automatic check_state(input string tag, input int k);
    logic [9:0] ed;
    logic       ec;
    ed = 10'(1 << k);
    ec = (k < 5);
    n_chk++;
    if (dec_q !== ed || carry_n !== ec) begin
      n_bad++;
      $display("FAIL %s: dec_q=%b carry_n=%b expected dec_q=%b carry_n=%b",
               tag, dec_q, carry_n, ed, ec);
    end
  endtask

  task automatic drive(input logic r, input logic f);
    @(negedge clk);
    trig_rise   = r;
    trig_fall_n = f;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse();
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
  endtask

  task automatic load(input logic [4:0] c);
    @(negedge clk);
    test_ld   = 1'b1;
    test_code = c;
    @(negedge clk);
    test_ld   = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog (R1..R10 run): still running, expected finish");
    summary();
    $finish;
  end

  initial begin
    mreset = 1'b1; trig_rise = 1'b0; trig_fall_n = 1'b0;
    test_ld = 1'b0; test_code = '0;
    repeat (6) @(negedge clk);
    check_state("R1 reset state", 0);
    mreset = 1'b0;
    repeat (5) @(negedge clk);
    check_state("R1 after release", 0);

    // Counting on the rising-edge line, including wraps (R3, R2, R6, R9).
    st = 0;
    for (int i = 0; i < 25; i++) begin
      drive(1'b1, 1'b0);
      st = (st + 1) % 10;
      check_state("R3 rise count", st);
      drive(1'b0, 1'b0);
      check_state("R5 falling trig_rise ignored", st);
    end

    drive(1'b1, 1'b1);
    check_state("R5 rise while trig_fall_n high ignored", st);
    // Counting on the falling-edge line (R4, R9).
    for (int i = 0; i < 15; i++) begin
      drive(1'b1, 1'b0);
      st = (st + 1) % 10;
      check_state("R4 fall count", st);
      drive(1'b1, 1'b1);
      check_state("R5 rising trig_fall_n ignored", st);
    end
    drive(1'b0, 1'b1);
    check_state("R5 trig_rise fall ignored", st);
    drive(1'b0, 1'b0);
    check_state("R5 fall while trig_rise low ignored", st);

    pulse();
    st = (st + 1) % 10;
    check_state("R3 count before reset", st);

    // Asynchronous reset between clock edges (R1).
    @(negedge clk);
    #1 mreset = 1'b1;
    #1 check_state("R1 immediate reset", 0);

    // Edge launched while reset is high, then at release (R10).
    repeat (2) @(negedge clk);
    trig_rise = 1'b1;
    repeat (3) @(negedge clk);
    trig_rise = 1'b0;
    repeat (6) @(negedge clk);
    trig_rise = 1'b1;
    mreset    = 1'b0;
    repeat (6) @(negedge clk);
    check_state("R10 edge at release discarded", 0);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    check_state("R10 counts resume", 1);
    drive(1'b0, 1'b0);

    // Legal loads (R8, R2 encoding).
    for (int k = 0; k < 10; k++) begin
      load(jcode(k));
      check_state("R8 legal load", k);
    end

    // Every illegal code recovers (R7, R8).
    for (int c = 0; c < 32; c++) begin
      if (!is_legal(5'(c))) begin
        int steps;
        int idx;
        load(5'(c));
        n_chk++;
        if ($onehot(dec_q)) begin
          n_bad++;
          $display("FAIL R8 illegal code %b: dec_q=%b expected not one-hot", 5'(c), dec_q);
        end
        steps = 0;
        while (!$onehot(dec_q) && steps < 12) begin
          pulse();
          steps++;
        end
        n_chk++;
        if (!$onehot(dec_q) || steps > 11) begin
          n_bad++;
          $display("FAIL R7 code %b: %0d counts, dec_q=%b expected one-hot within 11",
                   5'(c), steps, dec_q);
        end else begin
          idx = hot_index(dec_q);
          for (int j = 1; j <= 10; j++) begin
            pulse();
            check_state("R7 sequence after recovery", (idx + j) % 10);
          end
        end
      end
    end

    summary();
    $finish;
  end
endmodule